// File: doc/BRIEF.md
# Queued SPI Master

The block is an SPI master that runs a batch of serial transfers from on-chip queues without any processor involvement. Software uses a small register bus to fill a queue of command slots and a transmit byte memory. It then sets a first-slot pointer and a last-slot pointer and writes a start bit. The engine walks the slots in order. For each slot it asserts the selected chip-select line, shifts the slot's data MSB first on one lane or on four lanes, stores the received bits in a receive byte memory, and then either keeps or drops chip select. When the batch ends it sets a done flag.

Each command slot controls its own word size (8 or 16 bits), lane count, lane direction for four-lane reads, chip-select line, and whether chip select stays low after the slot. A keep-after-batch bit, written together with the start bit, lets one chip-select frame continue across batches that are started separately. A lock bit on its own output tells an outside arbiter to hold the bus for the frame. The register bus has no back-pressure: a write takes effect at the clock edge where it is presented, and a read returns its data in the same cycle. The data memories are the only data path, so the block has no streaming handshake.

Top module: `qspi_queue_master`

## Requirements
- R1: The half period of the serial clock is DIV system clocks, where DIV is the 8-bit register at control index 0. A DIV of 0 acts as 1.
- R2: Configuration index 1 holds bit2 = enable, bit1 = idle clock level, and bit0 = phase. With phase 0, data is sampled on the leading edge. With phase 1, data is sampled on the trailing edge. Data is sent MSB first.
- R3: A write with bit0 = 1 to the start register (index 4) begins a batch only when the block is idle and enable is 1. Any other such write starts nothing.
- R4: Slots run from the first pointer (index 2) to the last pointer (index 3), both included, and the slot number wraps modulo 16. The slot word is: bit5 keep, bit4 quad, bit3 quad-input, bit2 wide (16-bit), bits1:0 chip-select line.
- R5: Only the selected chip-select line goes low. It falls one half period before the first clock edge of the slot. It rises one half period after the last edge when the slot's keep bit is 0.
- R6: After the last slot of a batch, chip select stays low only when that slot's keep bit is 1 and bit1 was 1 in the start write.
- R7: Status (index 5) has bit0 = done and bit1 = busy. Done is set when the batch ends, and any write to index 5 clears it.
- R8: Slot i uses transmit bytes 2i and 2i+1. An 8-bit slot sends byte 2i and stores the received byte at receive entry 2i+1. A wide slot sends {2i, 2i+1} and stores into entries 2i and 2i+1 in the same order.
- R9: A quad slot moves 4 bits per clock on dout[3:0], with dout[3] carrying the higher bit. The output enables are 4'hF for a quad write, 4'h0 for a quad-input slot, and 4'h1 for a single-lane slot. A single-lane slot receives on din[1].
- R10: While busy, writes to the divider, configuration, pointers, command slots and transmit memory are ignored.
- R11: Bit0 of index 6 drives bus_lock.
- R12: After reset, all chip selects are high, the clock is low, the output enables are 0 and status reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Region in bits 6:5 (control, command, transmit, receive), index below |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, valid in the same cycle |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 4 | Active-low chip selects |
| spi_dout | output | 4 | Lane output data |
| spi_oe | output | 4 | Lane output enables |
| spi_din | input | 4 | Lane input data |
| bus_lock | output | 1 | Frame lock toward an outside arbiter |

## Verification
The bench connects the lanes in loopback and records edges, sampled bits, chip-select falls and rises, and output enables. This catches a wrong sampling phase, which would scramble the captured word, and a wrong lane order in quad mode. It runs a batch that wraps from slot 15 to slot 1. A sequencer that mishandled the wrap would run the wrong number of edges or drop chip select at the wrong times. It also extends one frame across two batches and checks that chip select never rises between them. Further tests check that transmit data written during a batch is left unchanged, that a start with enable off produces no clock edges, and that a divider of zero runs at one clock per half period.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int NCS = 4;

  typedef struct packed {
    logic       keep;
    logic       quad;
    logic       qin;
    logic       wide;
    logic [1:0] cs;
  } slot_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD, ST_GAP} st_t;

  localparam logic [1:0] RGN_CTL = 2'd0;
  localparam logic [1:0] RGN_CMD = 2'd1;
  localparam logic [1:0] RGN_TX  = 2'd2;
  localparam logic [1:0] RGN_RX  = 2'd3;

  localparam logic [2:0] IX_DIV  = 3'd0;
  localparam logic [2:0] IX_CFG  = 3'd1;
  localparam logic [2:0] IX_BEG  = 3'd2;
  localparam logic [2:0] IX_END  = 3'd3;
  localparam logic [2:0] IX_GO   = 3'd4;
  localparam logic [2:0] IX_STAT = 3'd5;
  localparam logic [2:0] IX_LOCK = 3'd6;
endpackage

// File: rtl/qspi_halfclk.sv
module qspi_halfclk #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;
  logic [DW-1:0] lim;

  assign lim  = (div == '0) ? DW'(1) : div;
  assign tick = run && (cnt == lim - DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + DW'(1);
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim > DW'(1)) |=> !tick); // R1
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] load_val,
  input  logic        quad,
  input  logic        sample,
  input  logic        shift,
  input  logic [3:0]  din,
  output logic [3:0]  dout,
  output logic [15:0] rx_word
);
  logic [15:0] sr;

  assign dout = quad ? sr[15:12] : {3'b000, sr[15]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr      <= '0;
      rx_word <= '0;
    end else if (load) begin
      sr      <= load_val;
      rx_word <= '0;
    end else begin
      if (shift)  sr      <= quad ? {sr[11:0], 4'b0000} : {sr[14:0], 1'b0};
      if (sample) rx_word <= quad ? {rx_word[11:0], din} : {rx_word[14:0], din[1]};
    end
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample && shift) && !(load && (sample || shift))); // R2
endmodule

// File: rtl/qspi_queue_master.sv
module qspi_queue_master
  import qspi_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int DIVW  = 8,
  localparam int PW    = $clog2(SLOTS),
  localparam int BYTES = 2 * SLOTS,
  localparam int BW    = $clog2(BYTES),
  localparam int AW    = BW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          spi_sck,
  output logic [NCS-1:0] spi_cs_n,
  output logic [3:0]    spi_dout,
  output logic [3:0]    spi_oe,
  input  logic [3:0]    spi_din,
  output logic          bus_lock
);
  logic [DIVW-1:0] div_q;
  logic            en_q, cpol_q, cpha_q, hold_q, done_q, lock_q;
  logic [PW-1:0]   start_ptr, stop_ptr, ptr, load_ptr;
  logic [5:0]      cmd_mem [SLOTS];
  logic [7:0]      tx_mem  [BYTES];
  logic [7:0]      rx_mem  [BYTES];

  st_t         state;
  slot_t       cur, nxt;
  logic [5:0]  k, k_last;
  logic        sck_q, cs_on, tick, busy, last_slot, go_ok, load_now;
  logic        sample, shift_e;
  logic [1:0]  cs_idx;
  logic [15:0] load_val, rx_word;
  logic [1:0]  rgn;
  logic        ctl_we;

  assign rgn       = reg_addr[AW-1 -: 2];
  assign ctl_we    = reg_we && rgn == RGN_CTL;
  assign busy      = state != ST_IDLE;
  assign last_slot = ptr == stop_ptr;
  assign go_ok     = ctl_we && reg_addr[2:0] == IX_GO && reg_wdata[0] && !busy && en_q;

  qspi_halfclk #(.DW(DIVW)) i_hclk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_q), .tick(tick)
  );

  always_comb begin
    k_last   = cur.quad ? (cur.wide ? 6'd7 : 6'd3) : (cur.wide ? 6'd31 : 6'd15);
    load_ptr = busy ? ptr + PW'(1) : start_ptr;
    nxt      = slot_t'(cmd_mem[load_ptr]);
    load_now = go_ok || (tick && ((state == ST_HOLD && !last_slot && cur.keep) ||
                                  state == ST_GAP));
    load_val = nxt.wide ? {tx_mem[{load_ptr, 1'b0}], tx_mem[{load_ptr, 1'b1}]}
                        : {tx_mem[{load_ptr, 1'b0}], 8'h00};
    sample   = state == ST_SHIFT && tick && (k[0] == cpha_q);
    shift_e  = state == ST_SHIFT && tick && (k[0] != cpha_q) && (k != 6'd0);
  end

  qspi_shift i_shift (
    .clk(clk), .rst_n(rst_n), .load(load_now), .load_val(load_val),
    .quad(cur.quad), .sample(sample), .shift(shift_e), .din(spi_din),
    .dout(spi_dout), .rx_word(rx_word)
  );

  // Slot sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ptr    <= '0;
      cur    <= '0;
      k      <= '0;
      sck_q  <= 1'b0;
      cs_on  <= 1'b0;
      cs_idx <= '0;
    end else if (load_now) begin
      ptr    <= load_ptr;
      cur    <= nxt;
      cs_idx <= nxt.cs;
      cs_on  <= 1'b1;
      k      <= '0;
      state  <= ST_SHIFT;
    end else begin
      case (state)
        ST_IDLE:  sck_q <= cpol_q;
        ST_SHIFT: if (tick) begin
          sck_q <= ~sck_q;
          k     <= k + 6'd1;
          if (k == k_last) state <= ST_HOLD;
        end
        ST_HOLD: if (tick) begin
          cs_on <= last_slot ? (cur.keep && hold_q) : 1'b0;
          state <= last_slot ? ST_IDLE : ST_GAP;
        end
        default: ;
      endcase
    end
  end

  // Received data and completion flag
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      for (int i = 0; i < BYTES; i++) rx_mem[i] <= '0;
    end else begin
      if (state == ST_HOLD && tick) begin
        if (cur.wide) rx_mem[{ptr, 1'b0}] <= rx_word[15:8];
        rx_mem[{ptr, 1'b1}] <= rx_word[7:0];
      end
      if (state == ST_HOLD && tick && last_slot) done_q <= 1'b1;
      else if (ctl_we && reg_addr[2:0] == IX_STAT) done_q <= 1'b0;
    end
  end

  // Programming registers and queue memories
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0; en_q <= 1'b0; cpol_q <= 1'b0; cpha_q <= 1'b0;
      start_ptr <= '0; stop_ptr <= '0; hold_q <= 1'b0; lock_q <= 1'b0;
      for (int i = 0; i < SLOTS; i++) cmd_mem[i] <= '0;
      for (int i = 0; i < BYTES; i++) tx_mem[i] <= '0;
    end else begin
      if (ctl_we) begin
        case (reg_addr[2:0])
          IX_DIV:  if (!busy) div_q <= reg_wdata[DIVW-1:0];
          IX_CFG:  if (!busy) {en_q, cpol_q, cpha_q} <= reg_wdata[2:0];
          IX_BEG:  if (!busy) start_ptr <= reg_wdata[PW-1:0];
          IX_END:  if (!busy) stop_ptr <= reg_wdata[PW-1:0];
          IX_GO:   if (go_ok) hold_q <= reg_wdata[1];
          IX_LOCK: lock_q <= reg_wdata[0];
          default: ;
        endcase
      end
      if (reg_we && !busy && rgn == RGN_CMD) cmd_mem[reg_addr[PW-1:0]] <= reg_wdata[5:0];
      if (reg_we && !busy && rgn == RGN_TX)  tx_mem[reg_addr[BW-1:0]]  <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (rgn)
      RGN_CTL: case (reg_addr[2:0])
        IX_DIV:  reg_rdata = 8'(div_q);
        IX_CFG:  reg_rdata = {5'b0, en_q, cpol_q, cpha_q};
        IX_BEG:  reg_rdata = 8'(start_ptr);
        IX_END:  reg_rdata = 8'(stop_ptr);
        IX_GO:   reg_rdata = {6'b0, hold_q, 1'b0};
        IX_STAT: reg_rdata = {6'b0, busy, done_q};
        IX_LOCK: reg_rdata = {7'b0, lock_q};
        default: reg_rdata = '0;
      endcase
      RGN_CMD: reg_rdata = {2'b00, cmd_mem[reg_addr[PW-1:0]]};
      RGN_TX:  reg_rdata = tx_mem[reg_addr[BW-1:0]];
      default: reg_rdata = rx_mem[reg_addr[BW-1:0]];
    endcase
  end

  assign spi_sck  = sck_q;
  assign spi_cs_n = cs_on ? ~(NCS'(1) << cs_idx) : '1;
  assign spi_oe   = !busy ? 4'h0 : (cur.quad ? (cur.qin ? 4'h0 : 4'hF) : 4'h1);
  assign bus_lock = lock_q;

  AST_CS_FALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&spi_cs_n) |-> busy); // R5
  AST_CS_RISE_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&spi_cs_n) |-> spi_sck == cpol_q); // R5
  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy)); // R7
  AST_PTR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(start_ptr) && $stable(stop_ptr))); // R10
endmodule

// File: tb/test_qspi_queue_master.sv
module test_qspi_queue_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       spi_sck, bus_lock;
  logic [3:0] spi_cs_n, spi_dout, spi_oe, spi_din;
  logic       lb_quad = 1'b0;

  always #2.5 clk = ~clk;

  assign spi_din = lb_quad ? spi_dout : {2'b00, spi_dout[0], 1'b0};

  qspi_queue_master i_qspi_queue_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_dout(spi_dout), .spi_oe(spi_oe),
    .spi_din(spi_din), .bus_lock(bus_lock)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor of the serial side
  logic        m_cpol = 0, m_cpha = 0, m_quad = 0, prev_sck = 0;
  logic [3:0]  prev_cs = 4'hF, cs_seen, oe_seen;
  logic [31:0] cap;
  int edges, t_e1, t_e2, t_el, t_csf, t_csr, cs_falls, cs_rises;

  task automatic clr_mon();
    @(posedge clk); #1;
    cap = 0; edges = 0; t_e1 = 0; t_e2 = 0; t_el = 0; t_csf = 0; t_csr = 0;
    cs_falls = 0; cs_rises = 0; cs_seen = 0; oe_seen = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_sck !== prev_sck) begin
        if (edges == 0) t_e1 = cyc;
        if (edges == 1) t_e2 = cyc;
        t_el = cyc;
        edges++;
        if ((prev_sck == m_cpol) != m_cpha)
          cap = m_quad ? {cap[27:0], spi_dout} : {cap[30:0], spi_dout[0]};
      end
      if (&prev_cs && !(&spi_cs_n)) begin t_csf = cyc; cs_falls++; end
      if (!(&prev_cs) && &spi_cs_n) begin t_csr = cyc; cs_rises++; end
      cs_seen |= ~spi_cs_n;
      oe_seen |= spi_oe;
    end
    prev_sck = spi_sck;
    prev_cs  = spi_cs_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(7'd5, s);
      if (s[0]) break;
    end
  endtask

  task automatic run(input logic [7:0] go);
    clr_mon();
    wr(7'd5, 8'h00);
    wr(7'd4, go);
    wait_done();
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0] mode; logic [7:0] div; logic [7:0] cmd; logic [7:0] t0; logic [7:0] t1;
  } vec_t;
  localparam vec_t VEC [5] = '{
    '{2'd0, 8'd2, 8'h00, 8'hA5, 8'h00},
    '{2'd3, 8'd3, 8'h05, 8'h3C, 8'h96},
    '{2'd1, 8'd1, 8'h02, 8'h81, 8'h00},
    '{2'd2, 8'd4, 8'h17, 8'hE7, 8'h18},
    '{2'd0, 8'd2, 8'h12, 8'h6B, 8'h00}
  };

  initial begin
    #900000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 cs_n", spi_cs_n, 4'hF);
    chk("R12 sck", spi_sck, 0);
    chk("R12 oe", spi_oe, 0);
    rd(7'd5, v); chk("R12 status", v, 0);

    // Vector table: one slot per entry, lanes in loopback
    foreach (VEC[n]) begin
      vec_t e;
      int bits, lanes;
      e = VEC[n];
      m_cpol = e.mode[1]; m_cpha = e.mode[0]; m_quad = e.cmd[4]; lb_quad = e.cmd[4];
      wr(7'd1, {5'b0, 1'b1, e.mode});
      wr(7'd0, e.div); wr(7'd2, 0); wr(7'd3, 0);
      wr(7'd32, e.cmd); wr(7'd64, e.t0); wr(7'd65, e.t1);
      run(8'h01);
      bits  = e.cmd[2] ? 16 : 8;
      lanes = e.cmd[4] ? 4 : 1;
      chk("R2 R9 captured word MSB first", cap & ((32'd1 << bits) - 1),
          e.cmd[2] ? {16'h0, e.t0, e.t1} : {24'h0, e.t0});
      chk("R4 edge count", edges, 2 * bits / lanes);
      chk("R1 half period", t_e2 - t_e1, e.div);
      chk("R5 cs setup", t_e1 - t_csf, e.div);
      chk("R5 cs release", t_csr - t_el, e.div);
      chk("R5 cs line", cs_seen, 4'b1 << e.cmd[1:0]);
      chk("R9 oe", oe_seen, e.cmd[4] ? 4'hF : 4'h1);
      chk("R2 idle level", spi_sck, m_cpol);
      rd(7'd97, v);
      if (e.cmd[2]) begin
        rd(7'd96, v2);
        chk("R8 wide rx first", v2, e.t0);
        chk("R8 wide rx second", v, e.t1);
      end else chk("R8 byte rx odd", v, e.t0);
    end
    m_quad = 0; lb_quad = 0; m_cpol = 0; m_cpha = 0;
    wr(7'd1, 8'h04);

    // R1 divider zero
    wr(7'd0, 0); wr(7'd32, 8'h00); wr(7'd64, 8'h55);
    run(8'h01);
    chk("R1 div0 half", t_e2 - t_e1, 1);

    // R4 wrap 15 -> 1
    wr(7'd0, 1); wr(7'd2, 15); wr(7'd3, 1);
    wr(7'd47, 8'h20); wr(7'd32, 8'h00); wr(7'd33, 8'h20);
    wr(7'd94, 8'h11); wr(7'd64, 8'h22); wr(7'd66, 8'h33);
    run(8'h01);
    chk("R4 wrap edges", edges, 48);
    chk("R5 wrap cs rises", cs_rises, 2);
    rd(7'd127, v); chk("R4 slot15 rx", v, 8'h11);
    rd(7'd97, v);  chk("R4 slot0 rx", v, 8'h22);
    rd(7'd99, v);  chk("R4 slot1 rx", v, 8'h33);
    chk("R6 last keep without hold", spi_cs_n, 4'hF);

    // R6 keep across batches
    wr(7'd2, 0); wr(7'd3, 0); wr(7'd32, 8'h20);
    run(8'h03);
    chk("R6 held after batch", spi_cs_n, 4'hE);
    run(8'h01);
    chk("R6 no refall", cs_falls, 0);
    chk("R6 released", cs_rises, 1);
    chk("R6 final cs", spi_cs_n, 4'hF);

    // R10 writes ignored while busy, R7 busy and done
    wr(7'd0, 8); wr(7'd32, 8'h04); wr(7'd64, 8'hAA); wr(7'd65, 8'hBB);
    wr(7'd5, 0); wr(7'd4, 1);
    wr(7'd64, 8'hFF); wr(7'd3, 5);
    rd(7'd5, v); chk("R7 busy bit", v[1], 1);
    wait_done();
    rd(7'd64, v); chk("R10 tx kept", v, 8'hAA);
    rd(7'd3, v);  chk("R10 stop ptr kept", v, 0);
    rd(7'd5, v);  chk("R7 done", v, 8'h01);
    wr(7'd5, 0);
    rd(7'd5, v);  chk("R7 done cleared", v, 0);

    // R3 disabled start
    wr(7'd1, 8'h00);
    clr_mon();
    wr(7'd4, 1);
    repeat (20) @(negedge clk);
    rd(7'd5, v); chk("R3 no start status", v, 0);
    chk("R3 no edges", edges, 0);
    wr(7'd1, 8'h04);

    // R9 quad input keeps lanes released
    wr(7'd0, 2); wr(7'd32, 8'h18); wr(7'd64, 8'hC3);
    m_quad = 1; lb_quad = 1;
    run(8'h01);
    chk("R9 qin oe", oe_seen, 0);
    chk("R9 qin edges", edges, 4);
    rd(7'd97, v); chk("R9 qin rx", v, 8'hC3);

    // R11 lock
    wr(7'd6, 1); chk("R11 lock on", bus_lock, 1);
    wr(7'd6, 0); chk("R11 lock off", bus_lock, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule